// File: doc/BRIEF.md
# Metaframe Transmit Generator with Burst Gating

The block emits one 67-bit transmit word per clock: a 3-bit header plus a 64-bit body. The words are grouped into metaframes of `FRAME_LEN` words. Every metaframe has the same order. A synchronization word comes first. A word carrying the scrambler state follows it. Then come `FRAME_LEN-3` payload slots. A diagnostic word closes the frame. The output never stalls and never pauses. A single-cycle `frame_start` pulse accompanies each synchronization word as it leaves the block.

Payload comes from an upstream transmit FIFO over a ready/valid read port. Once per metaframe, in the cycle the frame begins, the block samples `burst_en`, and that sample governs every payload slot of the frame. When it is low, the block asks for nothing and every slot carries a SKIP control word. When it is high, the block offers a read in every payload slot. A slot the FIFO cannot fill receives a SKIP word in its place. The 2-bit `lane_status` input is captured at the same instant and placed in the frame's diagnostic word. The scrambling itself is done elsewhere; this block only carries the state word it is given.

Top module: `mframe_gen`

## Requirements
- R1: `frame_start` is high for exactly one cycle per metaframe, every `FRAME_LEN` cycles. It is high in the same cycle as the synchronization word on `tx_data`, and that word is `{6'b011110, 32'h78F678F6, 26'h1A55A5A}`.
- R2: Within a metaframe, position 0 is the sync word and position 1 is the scrambler word `{6'b001010, scr_state}`. The value of `scr_state` is the one sampled at the clock edge that produces this output word. Positions 2 to `FRAME_LEN-2` are payload slots, and position `FRAME_LEN-1` is the diagnostic word.
- R3: `burst_en` is sampled only in the cycle that starts a metaframe. Changing it at any other point in the frame has no effect on that frame's `fifo_ready` or payload slots.
- R4: When the sampled `burst_en` is 0, `fifo_ready` stays low for the whole metaframe and every payload slot carries the SKIP word `{6'b000111, 58'h21E1E1E1E1E1E1E}`.
- R5: When the sampled `burst_en` is 1, `fifo_ready` is high in every payload-slot cycle. A word accepted in a cycle where `fifo_ready` and `fifo_valid` are both high appears on `tx_data` at the next clock edge, with header 3'b001.
- R6: In a bursting payload slot where `fifo_valid` is low, the SKIP word is sent in place of data. No slot is delayed.
- R7: Sync, scrambler, SKIP and diagnostic words carry header 3'b010. Only payload taken from the FIFO carries header 3'b001.
- R8: The diagnostic word is `{6'b011001, 24'h0, st, 32'h0}`. `st` sits in bits [33:32] and is the `lane_status` value sampled in the cycle that started the same metaframe. Bits [31:0] are a zero check-value placeholder.
- R9: While `rst` is high, `tx_hdr`, `tx_data`, `frame_start` and `fifo_ready` are all zero. The first word after reset is released is a sync word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_en | input | 1 | Selects FIFO payload (1) or SKIP fill (0), sampled at the start of each frame |
| lane_status | input | 2 | Status value placed in the diagnostic word |
| scr_state | input | 58 | Scrambler state carried in the second word of each frame |
| fifo_data | input | 64 | Payload word offered by the transmit FIFO |
| fifo_valid | input | 1 | FIFO has a word available |
| fifo_ready | output | 1 | Block takes the offered word this cycle |
| tx_hdr | output | 3 | Header of the current output word |
| tx_data | output | 64 | Body of the current output word |
| frame_start | output | 1 | One-cycle pulse alongside each sync word |

## Verification
Some properties are checked by assertions on every cycle:
- each pulse coincides with the sync pattern under a control header;
- every accepted FIFO word reaches the output one edge later with the data header;
- a slot without a handshake always yields a control word;
- the frame-level burst decision never changes mid-frame and holds `fifo_ready` low when off;
- the diagnostic placeholder field is zero.

Other behaviour only the bench's sweeps can show, because it spans whole frames:
- the pulse period;
- the exact position of each word;
- status values reaching the right diagnostic word;
- `burst_en` changes mid-frame leaving that frame untouched.

These sweeps run over burst on/off, all four status values and three FIFO availability patterns.

// File: rtl/mfg_pkg.sv
package mfg_pkg;

   localparam int WORD_W = 64;
   localparam int HDR_W  = 3;
   localparam int TYPE_W = 6;
   localparam int BODY_W = WORD_W - TYPE_W;
   localparam int STAT_W = 2;
   localparam int STAT_LSB = 32;
   localparam int CHK_W  = 32;

   localparam logic [HDR_W-1:0] HDR_CTL  = 3'b010;
   localparam logic [HDR_W-1:0] HDR_DATA = 3'b001;
   localparam logic [HDR_W-1:0] HDR_IDLE = 3'b000;

   localparam logic [TYPE_W-1:0] TY_SYNC = 6'b011110;
   localparam logic [TYPE_W-1:0] TY_SCR  = 6'b001010;
   localparam logic [TYPE_W-1:0] TY_SKIP = 6'b000111;
   localparam logic [TYPE_W-1:0] TY_DIAG = 6'b011001;

   localparam logic [BODY_W-1:0] SYNC_BODY = {32'h78F6_78F6, 26'h1A5_5A5A};
   localparam logic [BODY_W-1:0] SKIP_BODY = 58'h21E_1E1E_1E1E_1E1E;

   typedef enum logic [1:0] {
      SL_SYNC = 2'd0,
      SL_SCR  = 2'd1,
      SL_PAY  = 2'd2,
      SL_DIAG = 2'd3
   } slot_e;

   function automatic logic [WORD_W-1:0] sync_word();
      return {TY_SYNC, SYNC_BODY};
   endfunction

   function automatic logic [WORD_W-1:0] skip_word();
      return {TY_SKIP, SKIP_BODY};
   endfunction

   function automatic logic [WORD_W-1:0] scr_word(input logic [BODY_W-1:0] st);
      return {TY_SCR, st};
   endfunction

   function automatic logic [WORD_W-1:0] diag_word(input logic [STAT_W-1:0] st);
      logic [WORD_W-1:0] w;
      w = '0;
      w[WORD_W-1 -: TYPE_W] = TY_DIAG;
      w[STAT_LSB +: STAT_W] = st;
      w[CHK_W-1:0]          = '0;
      return w;
   endfunction

endpackage

// File: rtl/mfg_sequencer.sv
module mfg_sequencer
   import mfg_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   localparam int POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [POS_W-1:0] pos,
   output slot_e            slot,
   output logic             at_start
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

   generate
      if (FRAME_LEN < 5) begin : g_len_bad
         $error("mfg_sequencer: FRAME_LEN must be at least 5");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (pos == LAST)
         pos <= '0;
      else
         pos <= pos + 1'b1;
   end

   always_comb begin
      if (pos == '0)
         slot = SL_SYNC;
      else if (pos == POS_W'(1))
         slot = SL_SCR;
      else if (pos == LAST)
         slot = SL_DIAG;
      else
         slot = SL_PAY;
   end

   assign at_start = (pos == '0) && !rst;

endmodule

// File: rtl/mfg_gate.sv
module mfg_gate
   import mfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              at_start,
   input  slot_e             slot,
   input  logic              burst_en,
   input  logic [STAT_W-1:0] lane_status,
   output logic              burst_q,
   output logic [STAT_W-1:0] stat_q,
   output logic              rd_ready
);

   always_ff @(posedge clk) begin
      if (rst) begin
         burst_q <= 1'b0;
         stat_q  <= '0;
      end else if (at_start) begin
         burst_q <= burst_en;
         stat_q  <= lane_status;
      end
   end

   assign rd_ready = burst_q && (slot == SL_PAY) && !rst;

endmodule

// File: rtl/mfg_assembler.sv
module mfg_assembler
   import mfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  slot_e             slot,
   input  logic              take,
   input  logic [WORD_W-1:0] pay_data,
   input  logic [BODY_W-1:0] scr_state,
   input  logic [STAT_W-1:0] stat_q,
   output logic [HDR_W-1:0]  tx_hdr,
   output logic [WORD_W-1:0] tx_data,
   output logic              frame_start
);

   logic [HDR_W-1:0]  nxt_hdr;
   logic [WORD_W-1:0] nxt_data;

   always_comb begin
      nxt_hdr  = HDR_CTL;
      nxt_data = skip_word();
      unique case (slot)
         SL_SYNC: nxt_data = sync_word();
         SL_SCR:  nxt_data = scr_word(scr_state);
         SL_DIAG: nxt_data = diag_word(stat_q);
         SL_PAY: begin
            if (take) begin
               nxt_hdr  = HDR_DATA;
               nxt_data = pay_data;
            end
         end
         default: nxt_data = skip_word();
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_hdr      <= HDR_IDLE;
         tx_data     <= '0;
         frame_start <= 1'b0;
      end else begin
         tx_hdr      <= nxt_hdr;
         tx_data     <= nxt_data;
         frame_start <= (slot == SL_SYNC);
      end
   end

endmodule

// File: rtl/mframe_gen.sv
module mframe_gen
   import mfg_pkg::*;
#(
   parameter int FRAME_LEN = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               burst_en,
   input  logic [1:0]         lane_status,
   input  logic [57:0]        scr_state,
   input  logic [63:0]        fifo_data,
   input  logic               fifo_valid,
   output logic               fifo_ready,
   output logic [2:0]         tx_hdr,
   output logic [63:0]        tx_data,
   output logic               frame_start
);

   localparam int POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

   generate
      if (WORD_W != 64 || BODY_W != 58 || HDR_W != 3) begin : g_fmt_bad
         $error("mframe_gen: word format constants out of range");
      end
   endgenerate

   logic [POS_W-1:0]  pos_w;
   slot_e             slot_w;
   logic              start_w;
   logic              burst_q;
   logic [STAT_W-1:0] stat_q;
   logic              take_w;

   mfg_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .pos      (pos_w),
      .slot     (slot_w),
      .at_start (start_w)
   );

   mfg_gate u_gate (
      .clk         (clk),
      .rst         (rst),
      .at_start    (start_w),
      .slot        (slot_w),
      .burst_en    (burst_en),
      .lane_status (lane_status),
      .burst_q     (burst_q),
      .stat_q      (stat_q),
      .rd_ready    (fifo_ready)
   );

   assign take_w = fifo_ready && fifo_valid;

   mfg_assembler u_asm (
      .clk         (clk),
      .rst         (rst),
      .slot        (slot_w),
      .take        (take_w),
      .pay_data    (fifo_data),
      .scr_state   (scr_state),
      .stat_q      (stat_q),
      .tx_hdr      (tx_hdr),
      .tx_data     (tx_data),
      .frame_start (frame_start)
   );

endmodule

// File: rtl/mframe_gen_chk.sv
module mframe_gen_chk
   import mfg_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   localparam int POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input logic             clk,
   input logic             rst,
   input logic             fifo_valid,
   input logic [63:0]      fifo_data,
   input logic             fifo_ready,
   input logic [2:0]       tx_hdr,
   input logic [63:0]      tx_data,
   input logic             frame_start,
   input logic [POS_W-1:0] pos,
   input logic             burst_q
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

   assert_sync_with_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (tx_hdr == HDR_CTL) && (tx_data == sync_word()));

   assert_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);

   assert_latch_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (pos != '0) |=> $stable(burst_q));

   assert_no_read_when_off_R4: assert property (@(posedge clk) disable iff (rst)
      !burst_q |-> !fifo_ready);

   assert_take_forwarded_R5: assert property (@(posedge clk) disable iff (rst)
      (fifo_ready && fifo_valid) |=> (tx_hdr == HDR_DATA) && (tx_data == $past(fifo_data)));

   assert_no_take_is_ctl_R6: assert property (@(posedge clk) disable iff (rst)
      !(fifo_ready && fifo_valid) |=> (tx_hdr == HDR_CTL));

   assert_diag_placeholder_R8: assert property (@(posedge clk) disable iff (rst)
      (pos == LAST) |=> (tx_hdr == HDR_CTL) && (tx_data[31:0] == 32'h0)
                        && (tx_data[63:58] == TY_DIAG));

endmodule

bind mframe_gen mframe_gen_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .fifo_valid  (fifo_valid),
   .fifo_data   (fifo_data),
   .fifo_ready  (fifo_ready),
   .tx_hdr      (tx_hdr),
   .tx_data     (tx_data),
   .frame_start (frame_start),
   .pos         (pos_w),
   .burst_q     (burst_q)
);

// File: tb/mframe_gen_test.sv
module mframe_gen_test;

   localparam int LEN    = 16;
   localparam int FRAMES = 24;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        burst_en = 1'b0;
   logic [1:0]  lane_status = 2'd0;
   logic [57:0] scr_state = '0;
   logic [63:0] fifo_data = '0;
   logic        fifo_valid = 1'b0;
   logic        fifo_ready;
   logic [2:0]  tx_hdr;
   logic [63:0] tx_data;
   logic        frame_start;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   mframe_gen #(.FRAME_LEN(LEN)) uut (
      .clk(clk), .rst(rst), .burst_en(burst_en), .lane_status(lane_status),
      .scr_state(scr_state), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
      .fifo_ready(fifo_ready), .tx_hdr(tx_hdr), .tx_data(tx_data),
      .frame_start(frame_start)
   );

   localparam logic [63:0] SYNC_W = {6'b011110, 32'h78F678F6, 26'h1A55A5A};
   localparam logic [63:0] SKIP_W = {6'b000111, 58'h21E1E1E1E1E1E1E};

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // frame-level stimulus plan: burst = i%2, status = (i/2)%4, fifo pattern = (i/8)%3
   function automatic logic f_burst(input int i); return i[0]; endfunction
   function automatic logic [1:0] f_stat(input int i); return 2'((i / 2) % 4); endfunction

   logic [2:0]  e_hdr;
   logic [63:0] e_data;
   logic        e_pulse;
   logic        m_burst;
   logic [1:0]  m_stat;
   logic [1:0]  dbg_st;

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 hdr", 128'(tx_hdr), 128'(3'b000));
      chk("R9 data", 128'(tx_data), 128'(64'h0));
      chk("R9 pulse", 128'(frame_start), 128'(1'b0));
      chk("R9 ready", 128'(fifo_ready), 128'(1'b0));
      burst_en    = f_burst(0);
      lane_status = f_stat(0);
      m_burst = 1'b0;
      m_stat  = 2'd0;
      for (int c = 0; c < FRAMES * LEN; c++) begin
         int p;
         int fi;
         int pat;
         p  = c % LEN;
         fi = c / LEN;
         if (c == 0) rst = 1'b0;
         if (c > 0) begin
            chk("R1 pulse", 128'(frame_start), 128'(e_pulse));
            chk("R7 hdr", 128'(tx_hdr), 128'(e_hdr));
            chk("R2 word", 128'(tx_data), 128'(e_data));
            if (e_data[63:58] == 6'b011001) begin
               dbg_st = tx_data[33:32];
               chk("R8 status", 128'(dbg_st), 128'(e_data[33:32]));
            end
         end
         // mid-frame change of burst/status (far from pulse window): R3
         if (p == 8) begin
            burst_en    = f_burst(fi + 1);
            lane_status = f_stat(fi + 1);
         end
         pat = (fi / 8) % 3;
         fifo_valid = (pat == 0) ? 1'b1 : (pat == 1) ? 1'b0 : c[0];
         fifo_data  = 64'(c) * 64'h9E37_79B9_7F4A_7C15;
         scr_state  = 58'(64'(c + 7) * 64'h0123_4567_89AB_CDEF);
         if (p == 0) begin
            m_burst = burst_en;
            m_stat  = lane_status;
         end
         #0;
         if (p >= 2 && p <= LEN - 2)
            chk(m_burst ? "R5 ready" : "R4 ready", 128'(fifo_ready), 128'(m_burst));
         else
            chk("R3 ready", 128'(fifo_ready), 128'(1'b0));
         e_pulse = (p == 0);
         e_hdr   = 3'b010;
         if (p == 0)
            e_data = SYNC_W;
         else if (p == 1)
            e_data = {6'b001010, scr_state};
         else if (p == LEN - 1)
            e_data = {6'b011001, 24'h0, m_stat, 32'h0};
         else if (m_burst && fifo_valid) begin
            e_hdr  = 3'b001;
            e_data = fifo_data;
         end else
            e_data = SKIP_W;   // R4 / R6
         @(negedge clk);
      end
      chk("R1 pulse", 128'(frame_start), 128'(e_pulse));
      chk("R2 word", 128'(tx_data), 128'(e_data));
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule